// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host side of a link to a 16-bit sampling converter that has a three-wire serial output. The block drives an active-low chip select and a serial clock, and it samples the converter's data line. A falling chip select does two things: it starts a conversion in the converter, and it opens the read frame. The converter runs its conversion from the serial clock. For this reason every frame carries four zero bits before the 16-bit word. In the long frame, four more zero bits follow the word.

A frame starts on a single-cycle start request. It can also start from an internal rate timer, which fires a frame at a fixed interval counted in system clocks. The serial clock comes from the system clock through a half-period divisor. The divisor and the quiet-time length are checked at elaboration against the converter's legal limits. When a frame ends, the block removes the padding bits, outputs the word with a one-cycle valid strobe, and flags a framing error if any padding bit was read as one. After each frame, the chip select stays high for a minimum quiet time before the next frame can start.

Top module: `serial_adc_reader`

## Requirements
- R1: After reset, `adc_cs_n_o` is 1, `adc_sclk_o` is 1, `result_valid_o` is 0, `result_o` is 0 and `frame_err_o` is 0.
- R2: While `adc_cs_n_o` is high, `adc_sclk_o` rests high. Inside a frame, each high phase and each low phase of `adc_sclk_o` lasts HALF_DIV system clocks.
- R3: The first falling edge of `adc_sclk_o` in a frame comes exactly HALF_DIV system clocks after `adc_cs_n_o` falls.
- R4: The value of `mode24_i` at the moment of launch sets the frame length. With `mode24_i` = 0 a frame has 20 falling edges of `adc_sclk_o`; with `mode24_i` = 1 it has 24.
- R5: The converter changes `adc_sdata_i` after each falling edge of `adc_sclk_o`. The block samples the line on the next rising edge. Sampled bit k (k = 1 is the first) is the value driven after falling edge k.
- R6: In both modes, sampled bits 5 to 20 form `result_o`, with bit 5 as the MSB.
- R7: `frame_err_o` is 1 if any of sampled bits 1 to 4 is 1. In 24-clock mode, any of bits 21 to 24 being 1 also sets it. In 20-clock mode, data past bit 20 has no effect on the flag.
- R8: `result_valid_o` is a one-cycle pulse. It rises in the same cycle that `adc_cs_n_o` returns high. `result_o` and `frame_err_o` change only with this pulse.
- R9: `result_valid_o` rises (2·N+1)·HALF_DIV system clocks after `adc_cs_n_o` falls, where N is 20 or 24.
- R10: Between two frames, `adc_cs_n_o` stays high for at least QUIET_CYC+1 system clocks.
- R11: A `start_i` pulse that arrives while a frame or quiet time is running is held, not lost. It launches one frame exactly QUIET_CYC+1 clocks after the chip select is released.
- R12: While `cont_en_i` is 1, frames launch every `rate_i` system clocks, as long as `rate_i` exceeds the length of a frame plus the quiet time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request for one frame |
| cont_en_i | input | 1 | Enables launching at a fixed rate |
| rate_i | input | RATE_W | Interval between launches in continuous mode, in system clocks |
| mode24_i | input | 1 | 0: 20-clock frame, 1: 24-clock frame |
| adc_cs_n_o | output | 1 | Active-low chip select / conversion start |
| adc_sclk_o | output | 1 | Serial clock to the converter, idles high |
| adc_sdata_i | input | 1 | Serial data from the converter |
| result_o | output | 16 | Last conversion word |
| result_valid_o | output | 1 | One-cycle strobe for a new result |
| frame_err_o | output | 1 | A padding bit of the last frame was nonzero |

## Verification
Once a start is accepted, the chip select falls on the next clock. The bench counts system clocks from that fall. It expects the first serial-clock fall at HALF_DIV and the valid strobe at (2·N+1)·HALF_DIV, with N taken from the mode the scoreboard recorded for that frame. It measures the chip-select high time between frames and expects it to be at least QUIET_CYC+1, and exactly that when a start was held. In continuous mode it expects the spacing between chip-select falls to equal `rate_i`. All outputs are sampled on the falling system-clock edge, so every count lines up with the registered edges of the design.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  localparam int WORD_BITS  = 16;
  localparam int PAD_BITS   = 4;
  localparam int LONG_BITS  = WORD_BITS + 2 * PAD_BITS;
  localparam int SHORT_BITS = WORD_BITS + PAD_BITS;
  localparam int CNT_W      = $clog2(LONG_BITS + 1);

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_QUIET = 2'd2
  } seq_state_t;

  // number of serial clock periods in one frame
  function automatic logic [CNT_W-1:0] frame_bits(input logic long_mode);
    return long_mode ? CNT_W'(LONG_BITS) : CNT_W'(SHORT_BITS);
  endfunction

  // the shift register holds the newest bit at position 0
  function automatic logic [WORD_BITS-1:0] pick_word(
    input logic [LONG_BITS-1:0] sh, input logic long_mode);
    return long_mode ? sh[PAD_BITS +: WORD_BITS] : sh[0 +: WORD_BITS];
  endfunction

  function automatic logic pad_bad(
    input logic [LONG_BITS-1:0] sh, input logic long_mode);
    if (long_mode)
      return (|sh[LONG_BITS-1 -: PAD_BITS]) | (|sh[PAD_BITS-1:0]);
    else
      return |sh[SHORT_BITS-1 -: PAD_BITS];
  endfunction

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int HALF_DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int DW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R2: the phase counter never runs past one half period
  assert_half_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R2: a stopped divider restarts from zero
  assert_run_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);

endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl #(
  parameter int RATE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cont_en_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              seq_idle,
  output logic              launch
);
  logic [RATE_W-1:0] tmr_q;
  logic              rate_tick;
  logic              pend_q;
  logic              want;

  // the timer fires once every rate_i clocks while enabled
  assign rate_tick = cont_en_i && ({1'b0, tmr_q} + 1'b1 >= {1'b0, rate_i});
  assign want      = pend_q | start_i | rate_tick;
  assign launch    = seq_idle & want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tmr_q <= '0;
    else if (!cont_en_i) tmr_q <= '0;
    else if (rate_tick)  tmr_q <= '0;
    else                 tmr_q <= tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= want & ~launch;
  end

  // R11: a request while busy is kept until the sequencer is idle
  assert_hold_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !seq_idle) |=> pend_q);

  // R11: a held request is never dropped without a launch
  assert_pend_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !launch) |=> pend_q);

  // R12: the rate timer restarts after each fire
  assert_timer_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rate_tick |=> tmr_q == '0);

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_rd_pkg::*;
#(
  parameter int QUIET_CYC = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch,
  input  logic                 mode24_i,
  input  logic                 sdata_i,
  input  logic                 tick,
  output logic                 cs_n_o,
  output logic                 sclk_o,
  output logic                 run_o,
  output logic                 idle_o,
  output logic [WORD_BITS-1:0] result_o,
  output logic                 valid_o,
  output logic                 err_o
);
  localparam int QW = $clog2(QUIET_CYC + 2) + 1;
  localparam logic [QW-1:0] QLAST = QW'(QUIET_CYC - 1);

  seq_state_t           st_q;
  logic                 cs_n_q, sclk_q, mode_q;
  logic [CNT_W-1:0]     bits_q;
  logic [LONG_BITS-1:0] sh_q;
  logic [QW-1:0]        qcnt_q;
  logic [WORD_BITS-1:0] res_q;
  logic                 valid_q, err_q;

  // named events used by the assertions
  logic sample_ev, fall_ev, end_ev;
  logic [CNT_W-1:0] nbits;

  assign nbits     = frame_bits(mode_q);
  assign sample_ev = (st_q == SEQ_SHIFT) && tick && !sclk_q;
  assign fall_ev   = (st_q == SEQ_SHIFT) && tick && sclk_q && (bits_q != nbits);
  assign end_ev    = (st_q == SEQ_SHIFT) && tick && sclk_q && (bits_q == nbits);

  assign run_o    = (st_q == SEQ_SHIFT);
  assign idle_o   = (st_q == SEQ_IDLE);
  assign cs_n_o   = cs_n_q;
  assign sclk_o   = sclk_q;
  assign result_o = res_q;
  assign valid_o  = valid_q;
  assign err_o    = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b1;
      mode_q  <= 1'b0;
      bits_q  <= '0;
      sh_q    <= '0;
      qcnt_q  <= '0;
      res_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (st_q)
        SEQ_IDLE: begin
          if (launch) begin
            st_q   <= SEQ_SHIFT;
            cs_n_q <= 1'b0;
            sclk_q <= 1'b1;
            bits_q <= '0;
            sh_q   <= '0;
            mode_q <= mode24_i;
          end
        end
        SEQ_SHIFT: begin
          if (sample_ev) begin
            sclk_q <= 1'b1;
            sh_q   <= {sh_q[LONG_BITS-2:0], sdata_i};
            bits_q <= bits_q + 1'b1;
          end else if (fall_ev) begin
            sclk_q <= 1'b0;
          end else if (end_ev) begin
            st_q    <= SEQ_QUIET;
            cs_n_q  <= 1'b1;
            qcnt_q  <= '0;
            valid_q <= 1'b1;
            res_q   <= pick_word(sh_q, mode_q);
            err_q   <= pad_bad(sh_q, mode_q);
          end
        end
        SEQ_QUIET: begin
          qcnt_q <= qcnt_q + 1'b1;
          if (qcnt_q >= QLAST) st_q <= SEQ_IDLE;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  // checker-side count of chip-select high cycles, saturating
  logic [QW-1:0] hi_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        hi_cnt_q <= QW'(QUIET_CYC + 1);
    else if (!cs_n_q)                  hi_cnt_q <= '0;
    else if (hi_cnt_q <= QW'(QUIET_CYC)) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  assert_idle_clock_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  assert_setup_before_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> sclk_o);

  assert_bit_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bits_q <= frame_bits(1'b1));

  assert_sample_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_ev |=> $rose(sclk_o));

  assert_valid_with_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $rose(cs_n_o));

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_result_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(result_o));

  assert_quiet_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> hi_cnt_q >= QW'(QUIET_CYC));

endmodule

// File: rtl/serial_adc_reader.sv
module serial_adc_reader
  import adc_rd_pkg::*;
#(
  parameter longint SYS_CLK_HZ = 125_000_000,
  parameter int     HALF_DIV   = 32,
  parameter int     QUIET_CYC  = 16,
  parameter int     RATE_W     = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 cont_en_i,
  input  logic [RATE_W-1:0]    rate_i,
  input  logic                 mode24_i,
  output logic                 adc_cs_n_o,
  output logic                 adc_sclk_o,
  input  logic                 adc_sdata_i,
  output logic [WORD_BITS-1:0] result_o,
  output logic                 result_valid_o,
  output logic                 frame_err_o
);
  // serial clock = SYS_CLK_HZ / (2*HALF_DIV) must lie in 250 kHz .. 2.5 MHz
  localparam longint HALF_L   = longint'(HALF_DIV);
  localparam bit     SCLK_LO  = SYS_CLK_HZ <= 64'd5_000_000 * HALF_L;
  localparam bit     SCLK_HI  = SYS_CLK_HZ >= 64'd500_000 * HALF_L;
  // quiet time of QUIET_CYC clocks must cover 100 ns
  localparam bit     QUIET_OK = longint'(QUIET_CYC) * 64'd10_000_000 >= SYS_CLK_HZ;

  if (!(SCLK_LO && SCLK_HI)) begin : g_bad_div
    $error("serial_adc_reader: HALF_DIV gives a serial clock outside 250 kHz to 2.5 MHz");
  end
  if (!QUIET_OK || QUIET_CYC < 1) begin : g_bad_quiet
    $error("serial_adc_reader: QUIET_CYC is shorter than 100 ns");
  end
  if (HALF_DIV < 2) begin : g_bad_half
    $error("serial_adc_reader: HALF_DIV must be at least 2");
  end

  logic launch, seq_idle, div_run, div_tick;

  adc_start_ctrl #(.RATE_W(RATE_W)) u_start (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .cont_en_i (cont_en_i),
    .rate_i    (rate_i),
    .seq_idle  (seq_idle),
    .launch    (launch)
  );

  adc_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (div_run),
    .tick  (div_tick)
  );

  adc_frame_ctrl #(.QUIET_CYC(QUIET_CYC)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .mode24_i (mode24_i),
    .sdata_i  (adc_sdata_i),
    .tick     (div_tick),
    .cs_n_o   (adc_cs_n_o),
    .sclk_o   (adc_sclk_o),
    .run_o    (div_run),
    .idle_o   (seq_idle),
    .result_o (result_o),
    .valid_o  (result_valid_o),
    .err_o    (frame_err_o)
  );

  // R10/R11: a launch always lowers the chip select on the next clock
  assert_launch_lowers_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !adc_cs_n_o);

endmodule

// File: tb/serial_adc_reader_test.sv
module serial_adc_reader_test;
  localparam int H    = 32;
  localparam int Q    = 16;
  localparam int RW   = 20;
  localparam int RATE = 2000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          cont_en_i = 1'b0;
  logic [RW-1:0] rate_i = '0;
  logic          mode24_i = 1'b0;
  logic          adc_cs_n_o, adc_sclk_o;
  logic          adc_sdata_i = 1'b0;
  logic [15:0]   result_o;
  logic          result_valid_o, frame_err_o;

  always #4 clk = ~clk;

  serial_adc_reader #(.SYS_CLK_HZ(125_000_000), .HALF_DIV(H), .QUIET_CYC(Q), .RATE_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_en_i(cont_en_i),
    .rate_i(rate_i), .mode24_i(mode24_i), .adc_cs_n_o(adc_cs_n_o),
    .adc_sclk_o(adc_sclk_o), .adc_sdata_i(adc_sdata_i), .result_o(result_o),
    .result_valid_o(result_valid_o), .frame_err_o(frame_err_o)
  );

  typedef struct { logic [15:0] word; logic err; logic long_mode; } exp_t;
  exp_t        exp_q[$];
  logic [23:0] model_q[$];

  int checks = 0, errors = 0;
  int frames_done = 0, cs_falls = 0, last_gap = 0;
  bit cont_chk = 0, have_prev_fall = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // converter model: a new bit after every serial clock fall
  logic [23:0] cur_vec = '0;
  int          fall_idx = 0;
  always @(negedge adc_cs_n_o) begin
    cur_vec  = (model_q.size() != 0) ? model_q.pop_front() : 24'h0;
    fall_idx = 0;
  end
  always @(negedge adc_sclk_o) begin
    if (!adc_cs_n_o && fall_idx < 24) begin
      adc_sdata_i = cur_vec[23 - fall_idx];
      fall_idx++;
    end
  end

  // driver: push the frame the model will send and what must come out
  task automatic send(input logic [15:0] w, input logic [3:0] lead,
                      input logic [3:0] trail, input logic long_mode);
    exp_t e;
    e.word = w;
    e.long_mode = long_mode;
    e.err = (lead != 0) || (long_mode && trail != 0);
    model_q.push_back({lead, w, trail});
    exp_q.push_back(e);
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (Q + 4) @(negedge clk);
  endtask

  task automatic one_frame(input logic [15:0] w, input logic [3:0] lead,
                           input logic [3:0] trail, input logic long_mode);
    @(negedge clk) mode24_i = long_mode;
    send(w, lead, trail, long_mode);
    pulse_start();
    drain();
  endtask

  // monitor / scoreboard, sampled on the falling clock edge
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  int   since_fall = 0, sclk_falls = 0, hi_cnt = 0;
  longint cyc = 0, last_fall_cyc = 0;
  bit   seen_rise = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (prev_cs && !adc_cs_n_o) begin
        cs_falls++;
        since_fall = 0;
        sclk_falls = 0;
        if (seen_rise) begin
          last_gap = hi_cnt;
          check(hi_cnt >= Q + 1, "R10 cs high gap", hi_cnt, Q + 1);
        end
        if (cont_chk) begin
          if (have_prev_fall)
            check(cyc - last_fall_cyc == RATE, "R12 launch interval", cyc - last_fall_cyc, RATE);
          have_prev_fall = 1;
        end
        last_fall_cyc = cyc;
      end else begin
        since_fall++;
      end
      if (!adc_cs_n_o && prev_sclk && !adc_sclk_o) begin
        sclk_falls++;
        if (sclk_falls == 1)
          check(since_fall == H, "R3 first sclk fall", since_fall, H);
      end
      if (!prev_cs && adc_cs_n_o) begin
        hi_cnt = 1;
        seen_rise = 1;
      end else if (adc_cs_n_o) begin
        hi_cnt++;
      end
      if (result_valid_o) begin
        frames_done++;
        if (exp_q.size() == 0) begin
          check(0, "R8 unexpected valid", 1, 0);
        end else begin
          exp_t e;
          int n;
          e = exp_q.pop_front();
          n = e.long_mode ? 24 : 20;
          check(result_o == e.word, "R5 R6 result word", result_o, e.word);
          check(frame_err_o == e.err, "R7 framing flag", frame_err_o, e.err);
          check(sclk_falls == n, "R4 sclk falls per frame", sclk_falls, n);
          check(since_fall == (2 * n + 1) * H, "R9 valid latency", since_fall, (2 * n + 1) * H);
          check(adc_cs_n_o && !prev_cs, "R8 valid at cs release", adc_cs_n_o, 1);
        end
      end
      prev_cs   = adc_cs_n_o;
      prev_sclk = adc_sclk_o;
    end
  end

  // R2: serial clock rests high outside a frame
  always @(negedge clk) begin
    if (rst_n && adc_cs_n_o && !adc_sclk_o)
      check(0, "R2 sclk low while idle", adc_sclk_o, 1);
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int falls_before, done_before;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(adc_cs_n_o == 1'b1, "R1 cs after reset", adc_cs_n_o, 1);
    check(adc_sclk_o == 1'b1, "R1 sclk after reset", adc_sclk_o, 1);
    check(result_valid_o == 1'b0, "R1 valid after reset", result_valid_o, 0);
    check(result_o == 16'h0, "R1 result after reset", result_o, 0);
    check(frame_err_o == 1'b0, "R1 flag after reset", frame_err_o, 0);

    // short and long frames, clean padding (R4 R5 R6)
    one_frame(16'hA5C3, 4'h0, 4'h0, 1'b0);
    one_frame(16'h1234, 4'h0, 4'h0, 1'b1);
    one_frame(16'hFFFF, 4'h0, 4'h0, 1'b0);
    one_frame(16'h0000, 4'h0, 4'h0, 1'b1);
    // padding errors (R7)
    one_frame(16'h5A5A, 4'h8, 4'h0, 1'b0);
    one_frame(16'h8001, 4'h0, 4'h1, 1'b1);
    one_frame(16'h7FFE, 4'h1, 4'h0, 1'b1);
    // R7: trailing data is ignored in the short frame
    one_frame(16'hC0DE, 4'h0, 4'hF, 1'b0);
    check(frame_err_o == 1'b0, "R7 short frame ignores trailing bits", frame_err_o, 0);

    // R11: second start mid-frame is held and launches after the quiet time
    falls_before = cs_falls;
    done_before  = frames_done;
    @(negedge clk) mode24_i = 1'b1;
    send(16'h3C3C, 4'h0, 4'h0, 1'b1);
    send(16'hBEEF, 4'h0, 4'h0, 1'b1);
    pulse_start();
    repeat (200) @(negedge clk);
    pulse_start();
    drain();
    repeat (2000) @(negedge clk);
    check(cs_falls - falls_before == 2, "R11 held start gives one frame", cs_falls - falls_before, 2);
    check(frames_done - done_before == 2, "R11 two results", frames_done - done_before, 2);
    check(last_gap == Q + 1, "R11 held start gap", last_gap, Q + 1);

    // R12: continuous launching at a fixed rate
    falls_before = cs_falls;
    done_before  = frames_done;
    @(negedge clk) mode24_i = 1'b0;
    send(16'h0F0F, 4'h0, 4'h0, 1'b0);
    send(16'hF0F0, 4'h0, 4'h0, 1'b0);
    send(16'h1357, 4'h0, 4'h0, 1'b0);
    rate_i = RW'(RATE);
    cont_chk = 1;
    have_prev_fall = 0;
    cont_en_i = 1'b1;
    while (frames_done - done_before < 3) @(negedge clk);
    cont_en_i = 1'b0;
    cont_chk = 0;
    drain();
    repeat (RATE) @(negedge clk);
    check(cs_falls - falls_before == 3, "R12 frames in continuous run", cs_falls - falls_before, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule